// File: doc/BRIEF.md
# Shadow Register Vsync Update Controller

This block keeps two copies of the configuration registers for a display controller with overlay windows. Software writes the pending copy through a single-cycle write port. The scan-out engine uses a shadow copy. The pending values reach the shadow copy only at a frame boundary, and only after software has armed an update request. Each window has its own protect bit. While the bit is set, that window's shadow values are held, so a window setup that is only partly written is never applied.

The bank has three groups of registers. The first is a control word. The second is a set of global frame-synchronised registers, such as timing and sizes. The third is a small set of registers for each window. Field 0 of each window carries that window's enable in bit 0. Video output has an enable that acts at once and a second enable that is frame-synchronised. The pending copy can be read back through one port, and the shadow copy in use through another.

Top module: `shadow_vsync_ctrl`

## Requirements
- R1: A synchronous `rst` clears everything: both copies, the protect bits, the update request and both video enables. A write to address 0 with bit 7 set does the same clear in the cycle of the write, and the other bits of that write are ignored. After the clear, `win_active` is 0.
- R2: A write updates only the pending copy. The pending value shows on `rd_data` one cycle after `rd_addr` is presented. The shadow copy does not change on a write.
- R3: The transfer happens on a clock edge where `frame_start` is high and the update request is armed. On that edge every global register is copied, together with the frame-synchronised video enable and every unprotected window. On a `frame_start` edge with no armed request, no shadow value changes.
- R4: The control word holds one protect bit per window, at bits 3 and up (window w uses bit 3+w). While a window is protected, an armed transfer leaves that window's shadow values as they were, and its pending values stay held. After the protect bit is cleared, the next armed transfer copies them.
- R5: Writing 1 to bit 2 of the control word arms the update request. Writing 0 to that bit has no effect on it. The request clears itself on the edge that performs the transfer. Reading the control word returns the request state in bit 2.
- R6: `win_active[w]` comes from the shadow copy of bit 0 of window field 0. When software clears that bit, the window keeps scanning until the next armed transfer.
- R7: Bit 0 of the control word is the immediate video enable. `video_on_now` follows it one cycle after the write. Bit 1 is the frame-synchronised enable, and `video_on_frame` takes its value only at an armed transfer.
- R8: A write and a transfer on the same edge: the transfer copies the pending value from before the write, and the new value waits for a later transfer. If a write that sets the request lands on the transferring edge, the request stays armed afterwards.
- R9: `shd_data` returns the shadow value at `shd_addr` one cycle later. At address 0 it returns the shadow frame-synchronised video enable in bit 1.
- R10: The address map is: control word at 0, global registers at 1 to NUM_GLB, and window w field f at 8 + w*WIN_REGS + f (for the default sizes). Addresses outside this map ignore writes and read back 0 on both ports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Pending-copy read address |
| rd_data | output | DATA_W | Pending-copy read data, registered |
| frame_start | input | 1 | One-cycle frame boundary pulse |
| shd_addr | input | ADDR_W | Shadow-copy read address |
| shd_data | output | DATA_W | Shadow-copy read data, registered |
| win_active | output | NUM_WIN | Per-window scan-out enable in use |
| video_on_now | output | 1 | Immediate video enable |
| video_on_frame | output | 1 | Frame-synchronised video enable in use |

## Verification
A register write can land on the same edge as the frame boundary transfer. The bench provokes this by raising `wr_en` and `frame_start` together. It then reads both copies and expects the shadow to hold the older value and the pending copy to hold the newer one.

In the same way, a write that re-arms the update request lands on the transferring edge. That case passes only if the transfer takes place and the control readback still shows the request armed.

// File: rtl/svu_pkg.sv
package svu_pkg;
  // control word bit positions (software decodes these)
  localparam int CTL_VID_NOW  = 0;
  localparam int CTL_VID_FRM  = 1;
  localparam int CTL_UPD      = 2;
  localparam int CTL_PROT_LSB = 3;
  localparam int CTL_SWRST    = 7;
  // window enable bit inside window field 0
  localparam int WEN_BIT      = 0;

  typedef enum logic [1:0] {
    AK_NONE = 2'd0,
    AK_CTRL = 2'd1,
    AK_GLB  = 2'd2,
    AK_WIN  = 2'd3
  } addr_kind_e;
endpackage

// File: rtl/svu_addr_dec.sv
module svu_addr_dec
  import svu_pkg::*;
#(
  parameter int ADDR_W   = 6,
  parameter int NUM_GLB  = 4,
  parameter int NUM_WIN  = 2,
  parameter int WIN_REGS = 4,
  parameter int IDX_W    = 4
) (
  input  logic [ADDR_W-1:0] addr,
  output addr_kind_e        kind,
  output logic [IDX_W-1:0]  idx
);
  localparam int GLB_BASE = 1;
  localparam int WIN_BASE = 1 << $clog2(NUM_GLB + 1);
  localparam int WIN_SPAN = NUM_WIN * WIN_REGS;

  always_comb begin
    int a;
    a    = int'(addr);
    kind = AK_NONE;
    idx  = '0;
    if (a == 0) begin
      kind = AK_CTRL;
    end else if (a >= GLB_BASE && a < GLB_BASE + NUM_GLB) begin
      kind = AK_GLB;
      idx  = IDX_W'(a - GLB_BASE);
    end else if (a >= WIN_BASE && a < WIN_BASE + WIN_SPAN) begin
      kind = AK_WIN;
      idx  = IDX_W'(NUM_GLB + a - WIN_BASE);
    end
  end
endmodule

// File: rtl/svu_active_bank.sv
module svu_active_bank
  import svu_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int NUM_WIN  = 2,
  parameter int NUM_REGS = 12,
  parameter int IDX_W    = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  addr_kind_e         wr_kind,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [DATA_W-1:0]  wr_data,
  input  addr_kind_e         rd_kind,
  input  logic [IDX_W-1:0]   rd_idx,
  input  logic               armed,
  output logic [DATA_W-1:0]  act_q [NUM_REGS],
  output logic [NUM_WIN-1:0] protect,
  output logic               vid_now,
  output logic               vid_frm_pend,
  output logic               sw_rst,
  output logic               req_set,
  output logic [DATA_W-1:0]  rd_data
);
  logic               ctrl_wr;
  logic               clr;
  logic [DATA_W-1:0]  ctrl_word;

  assign ctrl_wr = wr_en && (wr_kind == AK_CTRL);
  assign sw_rst  = ctrl_wr && wr_data[CTL_SWRST];
  assign req_set = ctrl_wr && !wr_data[CTL_SWRST] && wr_data[CTL_UPD];
  assign clr     = rst || sw_rst;

  always_ff @(posedge clk) begin
    if (clr) begin
      for (int i = 0; i < NUM_REGS; i++) act_q[i] <= '0;
      protect      <= '0;
      vid_now      <= 1'b0;
      vid_frm_pend <= 1'b0;
    end else if (wr_en) begin
      case (wr_kind)
        AK_CTRL: begin
          vid_now      <= wr_data[CTL_VID_NOW];
          vid_frm_pend <= wr_data[CTL_VID_FRM];
          protect      <= wr_data[CTL_PROT_LSB +: NUM_WIN];
        end
        AK_GLB, AK_WIN: act_q[wr_idx] <= wr_data;
        default: ;
      endcase
    end
  end

  always_comb begin
    ctrl_word                          = '0;
    ctrl_word[CTL_VID_NOW]             = vid_now;
    ctrl_word[CTL_VID_FRM]             = vid_frm_pend;
    ctrl_word[CTL_UPD]                 = armed;
    ctrl_word[CTL_PROT_LSB +: NUM_WIN] = protect;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      case (rd_kind)
        AK_CTRL:        rd_data <= ctrl_word;
        AK_GLB, AK_WIN: rd_data <= act_q[rd_idx];
        default:        rd_data <= '0;
      endcase
    end
  end

  // R7: immediate enable follows the written bit one cycle later
  a_r7_vid_now: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr && !wr_data[CTL_SWRST]) |=> (vid_now == $past(wr_data[CTL_VID_NOW])));

  // R1: software clear empties the pending copy
  a_r1_swrst_pending: assert property (@(posedge clk) disable iff (rst)
    sw_rst |=> (protect == '0 && !vid_now && !vid_frm_pend));
endmodule

// File: rtl/svu_update_ctrl.sv
module svu_update_ctrl #(
  parameter int NUM_WIN = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sw_rst,
  input  logic               frame_start,
  input  logic               req_set,
  input  logic [NUM_WIN-1:0] protect,
  output logic               armed,
  output logic               xfer_glb,
  output logic [NUM_WIN-1:0] xfer_win
);
  assign xfer_glb = frame_start && armed;

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    assign xfer_win[w] = xfer_glb && !protect[w];
  end

  always_ff @(posedge clk) begin
    if (rst || sw_rst)  armed <= 1'b0;
    else if (req_set)   armed <= 1'b1;
    else if (xfer_glb)  armed <= 1'b0;
  end

  // R5: request clears itself after the transfer
  a_r5_arm_clears: assert property (@(posedge clk) disable iff (rst)
    (xfer_glb && !req_set && !sw_rst) |=> !armed);

  // R8: a request landing on the transferring edge stays armed
  a_r8_req_wins: assert property (@(posedge clk) disable iff (rst)
    (req_set && !sw_rst) |=> armed);
endmodule

// File: rtl/svu_shadow_bank.sv
module svu_shadow_bank
  import svu_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int NUM_GLB  = 4,
  parameter int NUM_WIN  = 2,
  parameter int WIN_REGS = 4,
  parameter int NUM_REGS = 12,
  parameter int IDX_W    = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sw_rst,
  input  logic               xfer_glb,
  input  logic [NUM_WIN-1:0] xfer_win,
  input  logic [DATA_W-1:0]  act_q [NUM_REGS],
  input  logic               vid_frm_pend,
  input  addr_kind_e         rd_kind,
  input  logic [IDX_W-1:0]   rd_idx,
  output logic [DATA_W-1:0]  shd_rd_data,
  output logic [NUM_WIN-1:0] win_active,
  output logic               vid_frm_shd
);
  logic [DATA_W-1:0]   shd_q [NUM_REGS];
  logic [NUM_REGS-1:0] take;
  logic                clr;

  assign clr = rst || sw_rst;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_take
    if (i < NUM_GLB) begin : g_glb
      assign take[i] = xfer_glb;
    end else begin : g_w
      assign take[i] = xfer_win[(i - NUM_GLB) / WIN_REGS];
    end
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      for (int i = 0; i < NUM_REGS; i++) shd_q[i] <= '0;
      vid_frm_shd <= 1'b0;
    end else begin
      for (int i = 0; i < NUM_REGS; i++)
        if (take[i]) shd_q[i] <= act_q[i];
      if (xfer_glb) vid_frm_shd <= vid_frm_pend;
    end
  end

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_act
    assign win_active[w] = shd_q[NUM_GLB + w * WIN_REGS][WEN_BIT];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shd_rd_data <= '0;
    end else begin
      case (rd_kind)
        AK_CTRL: begin
          shd_rd_data              <= '0;
          shd_rd_data[CTL_VID_FRM] <= vid_frm_shd;
        end
        AK_GLB, AK_WIN: shd_rd_data <= shd_q[rd_idx];
        default:        shd_rd_data <= '0;
      endcase
    end
  end

  // R3: with no armed transfer, every shadow entry holds
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_chk
    a_r3_hold_unarmed: assert property (@(posedge clk) disable iff (rst)
      (!sw_rst && !xfer_glb) |=> $stable(shd_q[i]));
  end
endmodule

// File: rtl/shadow_vsync_ctrl.sv
module shadow_vsync_ctrl
  import svu_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 6,
  parameter int NUM_GLB  = 4,
  parameter int NUM_WIN  = 2,
  parameter int WIN_REGS = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic [DATA_W-1:0]  rd_data,
  input  logic               frame_start,
  input  logic [ADDR_W-1:0]  shd_addr,
  output logic [DATA_W-1:0]  shd_data,
  output logic [NUM_WIN-1:0] win_active,
  output logic               video_on_now,
  output logic               video_on_frame
);
  localparam int NUM_REGS = NUM_GLB + NUM_WIN * WIN_REGS;
  localparam int IDX_W    = $clog2(NUM_REGS);

  addr_kind_e         wr_kind, rd_kind, sh_kind;
  logic [IDX_W-1:0]   wr_idx, rd_idx, sh_idx;
  logic [DATA_W-1:0]  act_q [NUM_REGS];
  logic [NUM_WIN-1:0] protect;
  logic               vid_frm_pend;
  logic               sw_rst, req_set, armed, xfer_glb;
  logic [NUM_WIN-1:0] xfer_win;

  svu_addr_dec #(.ADDR_W(ADDR_W), .NUM_GLB(NUM_GLB), .NUM_WIN(NUM_WIN),
                 .WIN_REGS(WIN_REGS), .IDX_W(IDX_W))
    u_dec_wr (.addr(wr_addr), .kind(wr_kind), .idx(wr_idx));
  svu_addr_dec #(.ADDR_W(ADDR_W), .NUM_GLB(NUM_GLB), .NUM_WIN(NUM_WIN),
                 .WIN_REGS(WIN_REGS), .IDX_W(IDX_W))
    u_dec_rd (.addr(rd_addr), .kind(rd_kind), .idx(rd_idx));
  svu_addr_dec #(.ADDR_W(ADDR_W), .NUM_GLB(NUM_GLB), .NUM_WIN(NUM_WIN),
                 .WIN_REGS(WIN_REGS), .IDX_W(IDX_W))
    u_dec_sh (.addr(shd_addr), .kind(sh_kind), .idx(sh_idx));

  svu_active_bank #(.DATA_W(DATA_W), .NUM_WIN(NUM_WIN),
                    .NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_act (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_kind(wr_kind), .wr_idx(wr_idx),
    .wr_data(wr_data), .rd_kind(rd_kind), .rd_idx(rd_idx), .armed(armed),
    .act_q(act_q), .protect(protect), .vid_now(video_on_now),
    .vid_frm_pend(vid_frm_pend), .sw_rst(sw_rst), .req_set(req_set),
    .rd_data(rd_data));

  svu_update_ctrl #(.NUM_WIN(NUM_WIN)) u_upd (
    .clk(clk), .rst(rst), .sw_rst(sw_rst), .frame_start(frame_start),
    .req_set(req_set), .protect(protect), .armed(armed),
    .xfer_glb(xfer_glb), .xfer_win(xfer_win));

  svu_shadow_bank #(.DATA_W(DATA_W), .NUM_GLB(NUM_GLB), .NUM_WIN(NUM_WIN),
                    .WIN_REGS(WIN_REGS), .NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_shd (
    .clk(clk), .rst(rst), .sw_rst(sw_rst), .xfer_glb(xfer_glb),
    .xfer_win(xfer_win), .act_q(act_q), .vid_frm_pend(vid_frm_pend),
    .rd_kind(sh_kind), .rd_idx(sh_idx), .shd_rd_data(shd_data),
    .win_active(win_active), .vid_frm_shd(video_on_frame));

  // R4: a protected window's scan-out enable cannot move
  for (genvar w = 0; w < NUM_WIN; w++) begin : g_prot_chk
    a_r4_protect_hold: assert property (@(posedge clk) disable iff (rst)
      (protect[w] && !sw_rst) |=> $stable(win_active[w]));
  end

  // R6: window enables change only with an armed transfer or a clear
  a_r6_enable_at_frame: assert property (@(posedge clk) disable iff (rst)
    (!xfer_glb && !sw_rst) |=> $stable(win_active));

  // R1: software clear leaves nothing active or armed
  a_r1_swrst_all: assert property (@(posedge clk) disable iff (rst)
    sw_rst |=> (win_active == '0 && !armed && !video_on_frame));
endmodule

// File: tb/shadow_vsync_ctrl_test.sv
module shadow_vsync_ctrl_test;
  localparam int DW = 32;
  localparam int AW = 6;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [DW-1:0] rd_data;
  logic          frame_start = 1'b0;
  logic [AW-1:0] shd_addr = '0;
  logic [DW-1:0] shd_data;
  logic [1:0]    win_active;
  logic          video_on_now, video_on_frame;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  shadow_vsync_ctrl uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .frame_start(frame_start),
    .shd_addr(shd_addr), .shd_data(shd_data), .win_active(win_active),
    .video_on_now(video_on_now), .video_on_frame(video_on_frame));

  typedef struct packed {
    logic [1:0]  op;
    logic [5:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam logic [1:0] OP_WR = 2'd0; // write pending copy
  localparam logic [1:0] OP_CA = 2'd1; // check pending readback
  localparam logic [1:0] OP_CS = 2'd2; // check shadow readback
  localparam logic [1:0] OP_VS = 2'd3; // frame boundary pulse
  localparam int NV = 25;

  localparam vec_t VECS [NV] = '{
    '{OP_WR, 6'd1,  32'h1111_1111, 32'h0,          4'd2},
    '{OP_WR, 6'd8,  32'h0000_0001, 32'h0,          4'd2},
    '{OP_WR, 6'd12, 32'h0000_0001, 32'h0,          4'd2},
    '{OP_WR, 6'd13, 32'hABCD_0000, 32'h0,          4'd2},
    '{OP_CA, 6'd1,  32'h0,         32'h1111_1111,  4'd2},  // R2 pending visible
    '{OP_CS, 6'd1,  32'h0,         32'h0,          4'd2},  // R2 shadow untouched
    '{OP_VS, 6'd0,  32'h0,         32'h0,          4'd3},
    '{OP_CS, 6'd1,  32'h0,         32'h0,          4'd3},  // R3 unarmed: no copy
    '{OP_WR, 6'd0,  32'h0000_0004, 32'h0,          4'd5},
    '{OP_CA, 6'd0,  32'h0,         32'h0000_0004,  4'd5},  // R5 armed bit
    '{OP_VS, 6'd0,  32'h0,         32'h0,          4'd3},
    '{OP_CS, 6'd1,  32'h0,         32'h1111_1111,  4'd3},  // R3 global copied
    '{OP_CS, 6'd13, 32'h0,         32'hABCD_0000,  4'd3},  // R3 window copied
    '{OP_CA, 6'd0,  32'h0,         32'h0,          4'd5},  // R5 self-cleared
    '{OP_WR, 6'd0,  32'h0000_0008, 32'h0,          4'd4},
    '{OP_WR, 6'd9,  32'h0000_0055, 32'h0,          4'd4},
    '{OP_WR, 6'd13, 32'h0000_0066, 32'h0,          4'd4},
    '{OP_WR, 6'd0,  32'h0000_000C, 32'h0,          4'd4},
    '{OP_VS, 6'd0,  32'h0,         32'h0,          4'd4},
    '{OP_CS, 6'd13, 32'h0,         32'h0000_0066,  4'd4},  // R4 unprotected moves
    '{OP_CS, 6'd9,  32'h0,         32'h0,          4'd4},  // R4 protected holds
    '{OP_CA, 6'd9,  32'h0,         32'h0000_0055,  4'd4},  // R4 pending kept
    '{OP_WR, 6'd0,  32'h0000_0004, 32'h0,          4'd4},
    '{OP_VS, 6'd0,  32'h0,         32'h0,          4'd4},
    '{OP_CS, 6'd9,  32'h0,         32'h0000_0055,  4'd4}   // R4 released later
  };

  task automatic chk(input int req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL R%0d actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic do_vs();
    @(negedge clk); frame_start = 1'b1;
    @(negedge clk); frame_start = 1'b0;
  endtask

  task automatic rd_act(input logic [AW-1:0] a, output logic [DW-1:0] v);
    @(negedge clk); rd_addr = a;
    @(negedge clk); v = rd_data;
  endtask

  task automatic rd_shd(input logic [AW-1:0] a, output logic [DW-1:0] v);
    @(negedge clk); shd_addr = a;
    @(negedge clk); v = shd_data;
  endtask

  task automatic wr_with_vs(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d; frame_start = 1'b1;
    @(negedge clk); wr_en = 1'b0; frame_start = 1'b0;
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk(1, {30'd0, win_active}, 32'h0);
    chk(1, {30'd0, video_on_now, video_on_frame}, 32'h0);
    rd_act(6'd0, v); chk(1, v, 32'h0);

    for (int i = 0; i < NV; i++) begin
      case (VECS[i].op)
        OP_WR: do_wr(VECS[i].addr, VECS[i].data);
        OP_VS: do_vs();
        OP_CA: begin rd_act(VECS[i].addr, v); chk(int'(VECS[i].req), v, VECS[i].exp); end
        default: begin rd_shd(VECS[i].addr, v); chk(int'(VECS[i].req), v, VECS[i].exp); end
      endcase
    end

    // R6: clearing a window enable waits for an armed frame boundary
    chk(6, {30'd0, win_active}, 32'h3);
    do_wr(6'd12, 32'h0);
    chk(6, {30'd0, win_active}, 32'h3);
    do_wr(6'd0, 32'h4);
    chk(6, {30'd0, win_active}, 32'h3);
    do_vs();
    chk(6, {30'd0, win_active}, 32'h1);

    // R7: immediate vs frame-synchronised video enable
    do_wr(6'd0, 32'h3);
    chk(7, {31'd0, video_on_now}, 32'h1);
    chk(7, {31'd0, video_on_frame}, 32'h0);
    do_vs();
    chk(7, {31'd0, video_on_frame}, 32'h0);
    do_wr(6'd0, 32'h7);
    do_vs();
    chk(7, {31'd0, video_on_frame}, 32'h1);
    rd_act(6'd0, v); chk(7, v, 32'h3);
    // R9: shadow readback of the control address
    rd_shd(6'd0, v); chk(9, v, 32'h2);

    // R8: write and transfer on one edge
    do_wr(6'd2, 32'h22);
    do_wr(6'd0, 32'h7);
    do_vs();
    rd_shd(6'd2, v); chk(8, v, 32'h22);
    do_wr(6'd0, 32'h7);
    wr_with_vs(6'd2, 32'h99);
    rd_shd(6'd2, v); chk(8, v, 32'h22);
    rd_act(6'd2, v); chk(8, v, 32'h99);
    rd_act(6'd0, v); chk(8, v, 32'h3);
    do_wr(6'd0, 32'h7);
    wr_with_vs(6'd0, 32'h7);
    rd_shd(6'd2, v); chk(8, v, 32'h99);
    rd_act(6'd0, v); chk(8, v, 32'h7);

    // R10: unmapped addresses
    do_wr(6'd20, 32'hFFFF_FFFF);
    do_wr(6'd6,  32'hFFFF_FFFF);
    rd_act(6'd20, v); chk(10, v, 32'h0);
    rd_act(6'd6, v);  chk(10, v, 32'h0);
    do_vs();
    rd_shd(6'd20, v); chk(10, v, 32'h0);

    // R1: software clear through the control word
    do_wr(6'd0, 32'h80);
    chk(1, {30'd0, win_active}, 32'h0);
    chk(1, {30'd0, video_on_now, video_on_frame}, 32'h0);
    rd_act(6'd1, v); chk(1, v, 32'h0);
    rd_shd(6'd1, v); chk(1, v, 32'h0);
    rd_act(6'd0, v); chk(1, v, 32'h0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule